// File: doc/BRIEF.md
# Debug Monitor Key Unlock Gate

This block decides, once per power-up, whether a debug monitor session may see the contents of on-chip nonvolatile memory. Once power-on reset is released, it lets a fixed settling interval elapse. It then takes eight key bytes from the host's serial receiver and compares each one with the stored key byte at the same position. When the eighth byte has been taken, it latches an accepted or rejected verdict and asks the transmitter for a break character. The break tells the host that the monitor is ready for commands.

The verdict then controls two paths into protected memory. When the key was rejected, or no verdict exists yet, reads of protected memory return a fixed invalid byte. In the same state, an instruction fetch from protected memory produces a one-cycle illegal-address reset request. An accepted verdict persists through every reset except power-on. After a completed mass erase, every stored key byte compares as 0xFF.

Receive bytes arrive on a valid/ready stream. During the settling interval and during key collection the block holds `rx_ready` high, and bytes that arrive in the settling interval are discarded. After the verdict the receive stream is connected straight through to the command stream, so `rx_ready` follows `cmd_ready` and back-pressure from the command consumer reaches the receiver. A byte moves on any clock edge where both valid and ready are high.

Top module: `mon_key_gate`

## Requirements
- R1: For the first WAIT_CYC (default 4128) clock edges after power-on reset is released, received bytes are discarded with `rx_ready` high. They do not count toward the key.
- R2: Exactly KEY_LEN (8) accepted bytes form the key. Byte n in arrival order (n = 0 for the first) is compared with `key_store[8n+7:8n]`.
- R3: When all eight bytes match, `status[6]` reads 1 from the cycle after the eighth byte is accepted. Protected reads then return `mem_rdata` unchanged, and protected fetches raise no reset request.
- R4: When any byte mismatches, the remaining bytes are still consumed and `status[6]` reads 0. Protected reads (`rd_prot`=1) then return BAD_VAL (default 0xAD), while unprotected reads always return `mem_rdata`.
- R5: While the verdict is not "accepted", including before any verdict exists, a cycle with `fetch_valid`=1 and `fetch_prot`=1 makes `ill_rst_req` high for exactly the following cycle.
- R6: `brk_req` is high for exactly one cycle, the cycle after the eighth byte is accepted, whatever the verdict. It is high at no other time.
- R7: All bits of `status` other than bit 6 always read 0.
- R8: A soft reset (`rst_soft`=1 at a clock edge) leaves a latched verdict unchanged. If no verdict exists yet, it restarts the settling interval and discards the bytes collected so far. It also clears `ill_rst_req`.
- R9: Power-on reset (`rst_por_n`=0) clears the verdict, so `status` reads 0x00 and the key must be entered again.
- R10: After an `erase_done` pulse, every stored key byte compares as 0xFF until the next power-on reset.
- R11: Once a verdict exists, `cmd_valid`=`rx_valid`, `cmd_data`=`rx_data` and `rx_ready`=`cmd_ready`, and received bytes no longer affect the key logic.
- R12: Until a verdict exists, `cmd_valid` is 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_soft | input | 1 | Any other reset source, synchronous, active high |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Block accepts the received byte |
| rx_data | input | 8 | Received byte |
| cmd_valid | output | 1 | Command byte forwarded after the verdict |
| cmd_ready | input | 1 | Command consumer accepts |
| cmd_data | output | 8 | Forwarded command byte |
| key_store | input | 64 | Stored key, byte n at bits 8n+7:8n |
| erase_done | input | 1 | Mass erase finished (pulse) |
| rd_prot | input | 1 | Current read targets protected memory |
| mem_rdata | input | 8 | Array read data |
| rd_data | output | 8 | Read data delivered to the monitor |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_prot | input | 1 | Fetch targets protected memory |
| ill_rst_req | output | 1 | Illegal-address reset request |
| brk_req | output | 1 | Request to send a break character |
| status | output | 8 | Bit 6 = key accepted, others 0 |

## Verification
Register outputs change on the edge after their cause. `status`, `brk_req` and `ill_rst_req` therefore show the result of a byte or fetch presented before edge k during the cycle that follows edge k. The stream signals and `rd_data` are combinational, so they follow the present inputs and the present verdict. The bench drives inputs 2 ns after each rising edge and updates a behavioural model at each rising edge. At each falling edge it compares every output with the model, which puts each registered result in the cycle where it is due.

// File: rtl/mon_key_pkg.sv
package mon_key_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/mon_key_wait.sv
module mon_key_wait #(
  parameter int WAIT_CYC = 4128
) (
  input  logic clk,
  input  logic rst_por_n,
  input  logic restart,
  output logic armed_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)        cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == LIMIT);

  // once armed, only a restart can disarm
  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_por_n)
    (armed_o && !restart) |=> armed_o); // R1
endmodule

// File: rtl/mon_key_cmp.sv
module mon_key_cmp
  import mon_key_pkg::*;
#(
  parameter int KEY_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_por_n,
  input  logic                 rst_soft,
  input  logic                 take_i,
  input  byte_t                byte_i,
  input  logic [KEY_LEN*8-1:0] key_flat_i,
  input  logic                 erase_i,
  output logic                 done_o,
  output logic                 unlocked_o,
  output logic                 brk_o
);
  localparam int IW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(KEY_LEN - 1);

  byte_t         key_arr [KEY_LEN];
  logic [IW-1:0] idx_q;
  logic          fail_q, erased_q, mism;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_arr[g] = erased_q ? BLANK_BYTE : key_flat_i[g*8 +: 8];
  end

  assign mism = (byte_i != key_arr[idx_q]);

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) erased_q <= 1'b0;
    else if (erase_i) erased_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      idx_q      <= '0;
      fail_q     <= 1'b0;
      done_o     <= 1'b0;
      unlocked_o <= 1'b0;
      brk_o      <= 1'b0;
    end else begin
      brk_o <= 1'b0;
      if (rst_soft && !done_o) begin
        idx_q  <= '0;
        fail_q <= 1'b0;
      end else if (take_i && !done_o) begin
        if (idx_q == LAST) begin
          done_o     <= 1'b1;
          unlocked_o <= !(fail_q || mism);
          brk_o      <= 1'b1;
          idx_q      <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        fail_q <= fail_q || mism;
      end
    end
  end

  AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_por_n)
    brk_o |=> !brk_o); // R6
  AST_VERDICT_KEPT: assert property (@(posedge clk) disable iff (!rst_por_n)
    done_o |=> (done_o && $stable(unlocked_o))); // R8
  AST_BRK_WITH_VERDICT: assert property (@(posedge clk) disable iff (!rst_por_n)
    $rose(done_o) |-> brk_o); // R6
endmodule

// File: rtl/mon_key_guard.sv
module mon_key_guard
  import mon_key_pkg::*;
#(
  parameter byte_t BAD_VAL = 8'hAD
) (
  input  logic  clk,
  input  logic  rst_por_n,
  input  logic  rst_soft,
  input  logic  unlocked_i,
  input  logic  rd_prot_i,
  input  byte_t mem_rdata_i,
  output byte_t rd_data_o,
  input  logic  fetch_valid_i,
  input  logic  fetch_prot_i,
  output logic  ill_o
);
  assign rd_data_o = (rd_prot_i && !unlocked_i) ? BAD_VAL : mem_rdata_i;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)    ill_o <= 1'b0;
    else if (rst_soft) ill_o <= 1'b0;
    else               ill_o <= fetch_valid_i && fetch_prot_i && !unlocked_i;
  end

  AST_ILL_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_por_n)
    ill_o |-> $past(fetch_valid_i && fetch_prot_i && !rst_soft)); // R5
  AST_ILL_NOT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_por_n)
    (ill_o && $stable(unlocked_i)) |-> !unlocked_i); // R3
endmodule

// File: rtl/mon_key_gate.sv
module mon_key_gate
  import mon_key_pkg::*;
#(
  parameter int    KEY_LEN  = 8,
  parameter int    WAIT_CYC = 4128,
  parameter byte_t BAD_VAL  = 8'hAD,
  parameter int    STAT_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rst_por_n,
  input  logic                 rst_soft,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [7:0]           rx_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [7:0]           cmd_data,
  input  logic [KEY_LEN*8-1:0] key_store,
  input  logic                 erase_done,
  input  logic                 rd_prot,
  input  logic [7:0]           mem_rdata,
  output logic [7:0]           rd_data,
  input  logic                 fetch_valid,
  input  logic                 fetch_prot,
  output logic                 ill_rst_req,
  output logic                 brk_req,
  output logic [7:0]           status
);
  logic armed, done, unlocked, take;

  mon_key_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_por_n(rst_por_n),
    .restart(rst_soft && !done), .armed_o(armed)
  );

  assign take = rx_valid && armed && !done;

  mon_key_cmp #(.KEY_LEN(KEY_LEN)) u_cmp (
    .clk(clk), .rst_por_n(rst_por_n), .rst_soft(rst_soft),
    .take_i(take), .byte_i(rx_data), .key_flat_i(key_store),
    .erase_i(erase_done), .done_o(done), .unlocked_o(unlocked), .brk_o(brk_req)
  );

  mon_key_guard #(.BAD_VAL(BAD_VAL)) u_guard (
    .clk(clk), .rst_por_n(rst_por_n), .rst_soft(rst_soft),
    .unlocked_i(unlocked), .rd_prot_i(rd_prot), .mem_rdata_i(mem_rdata),
    .rd_data_o(rd_data), .fetch_valid_i(fetch_valid), .fetch_prot_i(fetch_prot),
    .ill_o(ill_rst_req)
  );

  assign rx_ready  = done ? cmd_ready : 1'b1;
  assign cmd_valid = done && rx_valid;
  assign cmd_data  = rx_data;

  always_comb begin
    status = '0;
    status[STAT_BIT] = unlocked;
  end

  AST_STATUS_NEEDS_VERDICT: assert property (@(posedge clk) disable iff (!rst_por_n)
    status[STAT_BIT] |-> done); // R3
  AST_CMD_AFTER_VERDICT: assert property (@(posedge clk) disable iff (!rst_por_n)
    cmd_valid |-> (done && $past(armed))); // R11
endmodule

// File: tb/mon_key_gate_bench.sv
module mon_key_gate_bench;
  localparam int W = 4128;
  localparam logic [7:0] BAD = 8'hAD;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_por_n = 0, rst_soft = 0, rx_valid = 0, cmd_ready = 0;
  logic [7:0] rx_data = 0, mem_rdata = 8'h5A;
  logic erase_done = 0, rd_prot = 0, fetch_valid = 0, fetch_prot = 0;
  logic [63:0] key_store;
  logic rx_ready, cmd_valid, ill_rst_req, brk_req;
  logic [7:0] cmd_data, rd_data, status;

  mon_key_gate u_mon_key_gate (
    .clk(clk), .rst_por_n(rst_por_n), .rst_soft(rst_soft),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .key_store(key_store), .erase_done(erase_done),
    .rd_prot(rd_prot), .mem_rdata(mem_rdata), .rd_data(rd_data),
    .fetch_valid(fetch_valid), .fetch_prot(fetch_prot),
    .ill_rst_req(ill_rst_req), .brk_req(brk_req), .status(status)
  );

  logic [7:0] key_q[$];
  initial begin
    for (int i = 0; i < 8; i++) key_q.push_back(8'h3C + 8'h17 * i[7:0]);
    for (int i = 0; i < 8; i++) key_store[i*8 +: 8] = key_q[i];
  end

  int checks = 0, errors = 0, cycles = 0;
  bit done_run = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural model
  int m_wait, m_idx;
  bit m_fail, m_done, m_unl, m_brk, m_ill, m_erased;

  always @(posedge clk) begin
    if (!rst_por_n) begin
      m_wait = 0; m_idx = 0; m_fail = 0; m_done = 0; m_unl = 0;
      m_brk = 0; m_ill = 0; m_erased = 0;
    end else begin
      automatic bit old_done = m_done;
      automatic logic [7:0] want = m_erased ? 8'hFF : key_store[m_idx*8 +: 8];
      m_ill = rst_soft ? 0 : (fetch_valid && fetch_prot && !m_unl);
      m_brk = 0;
      if (rst_soft && !old_done) begin
        m_wait = 0; m_idx = 0; m_fail = 0;
      end else begin
        if (rx_valid && m_wait == W && !old_done) begin
          if (rx_data != want) m_fail = 1;
          m_idx++;
          if (m_idx == 8) begin
            m_done = 1; m_unl = !m_fail; m_brk = 1; m_idx = 0;
          end
        end
        if (m_wait < W) m_wait++;
      end
      if (erase_done) m_erased = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R12/R11 rx_ready", rx_ready, m_done ? cmd_ready : 1'b1);
    chk("R12/R11 cmd_valid", cmd_valid, m_done && rx_valid);
    if (cmd_valid) chk("R11 cmd_data", cmd_data, rx_data);
    chk("R4/R3 rd_data", rd_data, (rd_prot && !m_unl) ? BAD : mem_rdata);
    chk("R3/R7 status", status, {1'b0, m_unl, 6'b0});
    chk("R6 brk_req", brk_req, m_brk);
    chk("R5 ill_rst_req", ill_rst_req, m_ill);
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_data = b; step(1); rx_valid = 0; step(1);
  endtask

  task automatic por();
    rst_por_n = 0; step(3); rst_por_n = 1;
    @(negedge clk); chk("R9 status after power-on", status, 8'h00);
  endtask

  task automatic send_key(logic [7:0] k[8]);
    for (int i = 0; i < 7; i++) send(k[i]);
    rx_valid = 1; rx_data = k[7]; step(1); rx_valid = 0;
    @(negedge clk); chk("R6 brk after eighth byte", brk_req, 1'b1);
    step(1);
    @(negedge clk); chk("R6 brk back low", brk_req, 1'b0);
  endtask

  task automatic fetch_probe();
    fetch_valid = 1; fetch_prot = 1; step(1); fetch_valid = 0; fetch_prot = 0; step(2);
  endtask

  initial begin
    logic [7:0] k[8];
    step(1);
    // scenario 1: early bytes ignored, good key accepted
    por();
    for (int i = 0; i < 8; i++) k[i] = key_q[i];
    for (int i = 0; i < 8; i++) send(k[i]);   // inside settling interval
    @(negedge clk); chk("R1 early bytes ignored", status, 8'h00);
    chk("R1 no break yet", brk_req, 1'b0);
    fetch_probe();                            // locked before verdict: R5
    step(W);
    send_key(k);
    @(negedge clk); chk("R3 accepted", status, 8'h40);
    rd_prot = 1; mem_rdata = 8'h77; step(1);
    @(negedge clk); chk("R3 true protected data", rd_data, 8'h77);
    fetch_probe();
    @(negedge clk); chk("R3 no reset request when unlocked", ill_rst_req, 1'b0);
    cmd_ready = 0; rx_valid = 1; rx_data = k[0] ^ 8'hFF; step(1);
    @(negedge clk); chk("R11 back-pressure", rx_ready, 1'b0);
    cmd_ready = 1; step(1); rx_valid = 0; step(1);
    rst_soft = 1; step(2); rst_soft = 0; step(2);
    @(negedge clk); chk("R8 verdict survives soft reset", status, 8'h40);
    // scenario 2: mismatch at byte 2
    por();
    step(W + 1);
    k[2] = k[2] ^ 8'h01;
    send_key(k);
    @(negedge clk); chk("R4 rejected", status, 8'h00);
    rd_prot = 1; mem_rdata = 8'h12; step(1);
    @(negedge clk); chk("R4 masked read", rd_data, BAD);
    rd_prot = 0; step(1);
    @(negedge clk); chk("R4 unprotected read", rd_data, 8'h12);
    fetch_probe();
    rst_soft = 1; step(1); rst_soft = 0;
    send(key_q[0]); step(2);
    @(negedge clk); chk("R8 rejection kept, no re-entry", status, 8'h00);
    // scenario 3: mismatch only on last byte; then reversed order
    por(); step(W + 1);
    for (int i = 0; i < 8; i++) k[i] = key_q[i];
    k[7] = ~k[7];
    send_key(k);
    @(negedge clk); chk("R2 last byte checked", status, 8'h00);
    por(); step(W + 1);
    for (int i = 0; i < 8; i++) k[i] = key_q[7-i];
    send_key(k);
    @(negedge clk); chk("R2 order matters", status, 8'h00);
    // scenario 4: soft reset mid-collection restarts interval
    por(); step(W + 1);
    for (int i = 0; i < 8; i++) k[i] = key_q[i];
    for (int i = 0; i < 3; i++) send(k[i]);
    rst_soft = 1; step(1); rst_soft = 0;
    for (int i = 0; i < 8; i++) send(k[i]);   // ignored: interval restarted
    @(negedge clk); chk("R8 collection restarted", status, 8'h00);
    step(W);
    send_key(k);
    @(negedge clk); chk("R8 key after restart", status, 8'h40);
    // scenario 5: erase makes key blank
    por();
    erase_done = 1; step(1); erase_done = 0;
    step(W);
    for (int i = 0; i < 8; i++) k[i] = 8'hFF;
    send_key(k);
    @(negedge clk); chk("R10 blank key accepted", status, 8'h40);
    step(3);
    finish_run();
  end
endmodule